// File: doc/BRIEF.md
# Paper-Tape Absolute Binary Loader

This block turns a byte stream from a paper-tape reader into writes to a word-addressed memory. Bytes arrive through a valid/ready handshake. The loader finds the records on the tape, builds 16-bit words from byte pairs and writes each data word to consecutive addresses. It checks every record against its checksum word and then stops with one of three outcomes: a clean finish, a checksum failure or a truncated stream.

A record begins with a nonzero byte that gives its word count. One filler byte follows and is thrown away. Next come the start address, the data words and a checksum word. Runs of zero bytes separate records. Any number of zeros may come before the first record. After a record, a run of more than `GAP_LIMIT` zeros ends the load. The reader reports that the tape is exhausted by raising `tape_end` while it offers no byte.

The target memory holds `MEM_WORDS` words. Words aimed past its top are dropped, but they still count toward the checksum. A `start` pulse clears the outcome and arms the parser. The outcome flag then holds until the next `start`.

Top module: `tape_abs_loader`

## Requirements
- R1: After `start`, any number of zero bytes is skipped. The first nonzero byte is taken as the record's word count (1 to 255).
- R2: The byte that follows the count byte is accepted and ignored, whatever its value, including zero.
- R3: Every 16-bit word on the tape (address, data and checksum) is formed from two consecutive bytes, high byte first.
- R4: The record's address word sets the first write address. Data word k of the record is written to that address plus k. `wr_en` rises the cycle after the low byte of the data word is accepted.
- R5: The checksum is the address word plus all data words, modulo 2^16. The count byte is not included. If the checksum word read after the data differs from it, loading stops with `load_cksum_err`.
- R6: If `tape_end` is seen with no byte offered while a record is incomplete (filler byte, address, data or checksum still pending), loading stops with `load_fmt_err`.
- R7: A data word whose address is at or above `MEM_WORDS` is not written. The address still advances and the word still counts toward the checksum.
- R8: After a record, loading ends with `load_done` when the (GAP_LIMIT+1)th consecutive zero byte is accepted (the eleventh with the default of 10). A nonzero byte that comes sooner starts the next record.
- R9: If `tape_end` is seen while the loader waits before the first record or between records, loading ends with `load_done` and no error.
- R10: At most one outcome flag is high at a time. It stays high until the next `start`. `tape_ready` stays low from the outcome until `start`, so later bytes cause no writes. A new `start` clears the outcome flags.
- R11: After reset and before the first `start`, `tape_ready`, `wr_en` and all outcome flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears the outcome and begins a load |
| tape_byte | input | 8 | Byte from the tape reader |
| tape_valid | input | 1 | `tape_byte` is offered |
| tape_ready | output | 1 | Loader accepts a byte in this cycle |
| tape_end | input | 1 | No further bytes will come; acted on only when no byte is offered |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | clog2(MEM_WORDS) | Memory write address |
| wr_data | output | 16 | Memory write data |
| load_done | output | 1 | Load finished without error |
| load_cksum_err | output | 1 | Load stopped on a checksum mismatch |
| load_fmt_err | output | 1 | Load stopped on a truncated record |

## Verification
The bench builds the loader with `MEM_WORDS` set to 64 and leaves `GAP_LIMIT` at 10. With a 64-word memory, randomly chosen record addresses up to 80 regularly run records across the top of memory, so the drop-but-count path is exercised often. The gap limit matches the required eleven-zero stop, so directed tapes with gaps of exactly ten and exactly eleven zeros hit both sides of the boundary. Random tapes mix leading zeros, several records, corrupted checksums, truncations and both ending styles. A reference parser in the bench predicts the outcome and the memory image for each tape.

// File: rtl/tal_pkg.sv
package tal_pkg;

    // Parser position within the tape stream
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,      // zeros before the first record, unbounded
        ST_GAP,       // zeros after a record, bounded
        ST_SKIP,      // filler byte after the count
        ST_ORG_HI,
        ST_ORG_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_SUM_HI,
        ST_SUM_LO,
        ST_FINAL
    } tal_state_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_OK,
        OUT_CSUM,
        OUT_FMT
    } tal_outcome_e;

endpackage

// File: rtl/tal_addr_seq.sv
module tal_addr_seq #(
    parameter int MEM_WORDS = 32768
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         step,
    input  logic [15:0]                  origin,
    output logic [$clog2(MEM_WORDS)-1:0] addr_lo,
    output logic                         in_range
);
    localparam int AW = $clog2(MEM_WORDS);
    localparam int PW = 17;   // one spare bit so the address never wraps

    logic [PW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = {1'b0, origin};
        end else if (step) begin
            addr_d = addr_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_lo  = addr_q[AW-1:0];
    assign in_range = (addr_q < PW'(MEM_WORDS));

    assert_step_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_q == $past(addr_q) + PW'(1)));

    assert_load_step_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/tal_sum_acc.sv
module tal_sum_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        add,
    input  logic [15:0] val,
    output logic [15:0] sum
);
    logic [15:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (load) begin
            sum_d = val;
        end else if (add) begin
            sum_d = sum_q + val;   // carries past bit 15 drop out
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

    assert_sum_modular_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !load) |=> (sum_q == 16'($past(sum_q) + $past(val))));

endmodule

// File: rtl/tal_zero_run.sv
module tal_zero_run #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = bump && (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && !hit) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/tape_abs_loader.sv
module tape_abs_loader
    import tal_pkg::*;
#(
    parameter int MEM_WORDS = 32768,
    parameter int GAP_LIMIT = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [7:0]                   tape_byte,
    input  logic                         tape_valid,
    output logic                         tape_ready,
    input  logic                         tape_end,
    output logic                         wr_en,
    output logic [$clog2(MEM_WORDS)-1:0] wr_addr,
    output logic [15:0]                  wr_data,
    output logic                         load_done,
    output logic                         load_cksum_err,
    output logic                         load_fmt_err
);
    localparam int ADDR_W = $clog2(MEM_WORDS);

    typedef struct packed {
        tal_state_e        state;
        tal_outcome_e      outcome;
        logic [7:0]        hi;
        logic [7:0]        left;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [15:0]       wr_data;
    } regs_t;

    regs_t r_d, r_q;

    logic              active, take, at_end;
    logic [15:0]       word;
    logic              a_load, a_step, s_load, s_add, z_clear, z_bump;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_in_range, run_hit;
    logic [15:0]       run_sum;

    assign active = (r_q.state != ST_IDLE) && (r_q.state != ST_FINAL);
    assign tape_ready = active && !start;
    assign take   = tape_valid && tape_ready;
    assign at_end = tape_end && !tape_valid && tape_ready;
    assign word   = {r_q.hi, tape_byte};

    tal_addr_seq #(.MEM_WORDS(MEM_WORDS)) i_addr (
        .clk(clk), .rst_n(rst_n), .load(a_load), .step(a_step),
        .origin(word), .addr_lo(cur_addr), .in_range(cur_in_range)
    );

    tal_sum_acc i_sum (
        .clk(clk), .rst_n(rst_n), .load(s_load), .add(s_add),
        .val(word), .sum(run_sum)
    );

    tal_zero_run #(.LIMIT(GAP_LIMIT)) i_run (
        .clk(clk), .rst_n(rst_n), .clear(z_clear), .bump(z_bump), .hit(run_hit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        a_load    = 1'b0;
        a_step    = 1'b0;
        s_load    = 1'b0;
        s_add     = 1'b0;
        z_clear   = 1'b0;
        z_bump    = 1'b0;

        if (start) begin
            r_d.state   = ST_LEAD;
            r_d.outcome = OUT_NONE;
            r_d.hi      = '0;
            r_d.left    = '0;
            z_clear     = 1'b1;
        end else begin
            case (r_q.state)
                ST_LEAD: begin
                    if (take) begin
                        if (tape_byte != 8'd0) begin
                            r_d.left  = tape_byte;
                            r_d.state = ST_SKIP;
                        end
                    end else if (at_end) begin
                        r_d.state   = ST_FINAL;
                        r_d.outcome = OUT_OK;
                    end
                end
                ST_GAP: begin
                    if (take) begin
                        if (tape_byte == 8'd0) begin
                            z_bump = 1'b1;
                            if (run_hit) begin
                                r_d.state   = ST_FINAL;
                                r_d.outcome = OUT_OK;
                            end
                        end else begin
                            r_d.left  = tape_byte;
                            r_d.state = ST_SKIP;
                        end
                    end else if (at_end) begin
                        r_d.state   = ST_FINAL;
                        r_d.outcome = OUT_OK;
                    end
                end
                ST_SKIP: begin
                    if (take) begin
                        r_d.state = ST_ORG_HI;
                    end
                end
                ST_ORG_HI: begin
                    if (take) begin
                        r_d.hi    = tape_byte;
                        r_d.state = ST_ORG_LO;
                    end
                end
                ST_ORG_LO: begin
                    if (take) begin
                        a_load    = 1'b1;
                        s_load    = 1'b1;
                        r_d.state = ST_DAT_HI;
                    end
                end
                ST_DAT_HI: begin
                    if (take) begin
                        r_d.hi    = tape_byte;
                        r_d.state = ST_DAT_LO;
                    end
                end
                ST_DAT_LO: begin
                    if (take) begin
                        r_d.wr_en   = cur_in_range;
                        r_d.wr_addr = cur_addr;
                        r_d.wr_data = word;
                        a_step      = 1'b1;
                        s_add       = 1'b1;
                        r_d.left    = r_q.left - 8'd1;
                        r_d.state   = (r_q.left == 8'd1) ? ST_SUM_HI : ST_DAT_HI;
                    end
                end
                ST_SUM_HI: begin
                    if (take) begin
                        r_d.hi    = tape_byte;
                        r_d.state = ST_SUM_LO;
                    end
                end
                ST_SUM_LO: begin
                    if (take) begin
                        if (word == run_sum) begin
                            z_clear   = 1'b1;
                            r_d.state = ST_GAP;
                        end else begin
                            r_d.state   = ST_FINAL;
                            r_d.outcome = OUT_CSUM;
                        end
                    end
                end
                default: ;
            endcase

            // a record cut short by the end of the tape
            if (at_end && (r_q.state != ST_LEAD) && (r_q.state != ST_GAP)) begin
                r_d.state   = ST_FINAL;
                r_d.outcome = OUT_FMT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, outcome: OUT_NONE, hi: '0, left: '0,
                     wr_en: 1'b0, wr_addr: '0, wr_data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en          = r_q.wr_en;
    assign wr_addr        = r_q.wr_addr;
    assign wr_data        = r_q.wr_data;
    assign load_done      = (r_q.outcome == OUT_OK);
    assign load_cksum_err = (r_q.outcome == OUT_CSUM);
    assign load_fmt_err   = (r_q.outcome == OUT_FMT);

    assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_done, load_cksum_err, load_fmt_err}));

    assert_quiet_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done || load_cksum_err || load_fmt_err) |-> !tape_ready);

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((load_done || load_cksum_err || load_fmt_err) && !start) |=>
            $stable({load_done, load_cksum_err, load_fmt_err}));

    assert_fmt_needs_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_fmt_err) |-> $past(tape_end && !tape_valid));

    assert_csum_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_cksum_err) |-> $past(tape_valid && tape_ready));

    assert_write_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(tape_valid && tape_ready));

endmodule

// File: tb/test_tape_abs_loader.sv
module test_tape_abs_loader;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 64;
    localparam int GL = 10;
    localparam int AW = $clog2(MW);
    localparam int TMAX = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    tape_byte = '0;
    logic          tape_valid = 1'b0;
    logic          tape_ready;
    logic          tape_end = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          load_done, load_cksum_err, load_fmt_err;

    tape_abs_loader #(.MEM_WORDS(MW), .GAP_LIMIT(GL)) i_tape_abs_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .tape_byte(tape_byte),
        .tape_valid(tape_valid), .tape_ready(tape_ready), .tape_end(tape_end),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_done(load_done), .load_cksum_err(load_cksum_err),
        .load_fmt_err(load_fmt_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  tape [0:TMAX-1];
    int          tlen;
    logic [15:0] exp_mem [0:MW-1];
    logic [15:0] got_mem [0:MW-1];
    int          got_writes;
    int          nchecks = 0;
    int          nfail = 0;

    // outcome encodings used by the reference parser
    localparam int OC_OK = 1, OC_CSUM = 2, OC_FMT = 3;

    always @(negedge clk) begin
        if (wr_en) begin
            got_mem[wr_addr] = wr_data;
            got_writes++;
        end
    end

    function automatic logic any_flag();
        return load_done | load_cksum_err | load_fmt_err;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int b);
        tape[tlen] = 8'(b);
        tlen++;
    endtask

    task automatic push_word(input int w);
        push((w >> 8) & 8'hFF);
        push(w & 8'hFF);
    endtask

    task automatic push_zeros(input int n);
        for (int i = 0; i < n; i++) push(0);
    endtask

    // mode 0: random data, 1: large data to force carries out of bit 15
    task automatic add_record(input int count, input int org, input int filler,
                              input bit bad, input int mode);
        logic [15:0] s;
        push(count);
        push(filler);
        push_word(org);
        s = 16'(org);
        for (int k = 0; k < count; k++) begin
            logic [15:0] d;
            d = (mode == 1) ? (16'hFF00 | 16'($urandom % 256)) : 16'($urandom);
            push_word(d);
            s = s + d;
        end
        push_word(bad ? int'(s ^ 16'h0100) : int'(s));
    endtask

    // Reference parser written from the requirements
    function automatic int ref_parse();
        int i = 0;
        bit first = 1'b1;
        for (int a = 0; a < MW; a++) exp_mem[a] = 16'hDEAD;
        forever begin
            int zeros = 0;
            int count;
            int addr;
            logic [15:0] s;
            logic [15:0] w;
            forever begin
                if (i >= tlen) return OC_OK;            // R9
                count = tape[i];
                i++;
                if (count != 0) break;
                zeros++;
                if (!first && zeros == GL + 1) return OC_OK;  // R8
            end
            first = 1'b0;
            if (i >= tlen) return OC_FMT;
            i++;                                      // filler, R2
            if (i + 2 > tlen) return OC_FMT;
            addr = {tape[i], tape[i+1]};
            s = 16'(addr);
            i += 2;
            for (int k = 0; k < count; k++) begin
                if (i + 2 > tlen) return OC_FMT;
                w = {tape[i], tape[i+1]};
                i += 2;
                if (addr < MW) exp_mem[addr] = w;
                addr++;
                s = s + w;
            end
            if (i + 2 > tlen) return OC_FMT;
            w = {tape[i], tape[i+1]};
            i += 2;
            if (w != s) return OC_CSUM;
        end
    endfunction

    task automatic send_byte(input logic [7:0] b);
        if ($urandom % 4 == 0) begin
            @(negedge clk);
            tape_valid = 1'b0;
        end
        @(negedge clk);
        tape_valid = 1'b1;
        tape_byte  = b;
        forever begin
            if (tape_ready) begin
                @(posedge clk);
                break;
            end
            if (any_flag()) break;
            @(negedge clk);
        end
    endtask

    task automatic run_load(input string mem_req);
        int exp_oc;
        int got_oc;
        int w0;
        bit rdy_seen;
        logic [2:0] flags_before;
        bit mem_ok;

        exp_oc = ref_parse();
        for (int a = 0; a < MW; a++) got_mem[a] = 16'hDEAD;
        got_writes = 0;

        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        for (int i = 0; i < tlen; i++) begin
            if (any_flag()) break;
            send_byte(tape[i]);
        end
        @(negedge clk);
        tape_valid = 1'b0;
        tape_end   = 1'b1;
        for (int c = 0; c < 40; c++) begin
            if (any_flag()) break;
            @(negedge clk);
        end
        @(negedge clk);

        got_oc = load_done ? OC_OK : load_cksum_err ? OC_CSUM : load_fmt_err ? OC_FMT : 0;
        case (exp_oc)
            OC_OK:   check(got_oc == exp_oc && !load_cksum_err && !load_fmt_err,
                           "R8 R9", "outcome", got_oc, exp_oc);
            OC_CSUM: check(got_oc == exp_oc && !load_done && !load_fmt_err,
                           "R5", "outcome", got_oc, exp_oc);
            default: check(got_oc == exp_oc && !load_done && !load_cksum_err,
                           "R6", "outcome", got_oc, exp_oc);
        endcase

        mem_ok = 1'b1;
        for (int a = 0; a < MW; a++) begin
            if (got_mem[a] !== exp_mem[a]) begin
                if (mem_ok)
                    check(1'b0, mem_req, $sformatf("memory word %0d", a),
                          int'(got_mem[a]), int'(exp_mem[a]));
                mem_ok = 1'b0;
            end
        end
        if (mem_ok) check(1'b1, mem_req, "memory image", 0, 0);

        // R10: bytes offered after the outcome are not taken
        tape_end = 1'b0;
        flags_before = {load_done, load_cksum_err, load_fmt_err};
        w0 = got_writes;
        rdy_seen = 1'b0;
        tape_valid = 1'b1;
        tape_byte  = 8'h5A;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (tape_ready) rdy_seen = 1'b1;
        end
        tape_valid = 1'b0;
        check(!rdy_seen && got_writes == w0, "R10", "ready or write after outcome",
              int'(rdy_seen), 0);
        check({load_done, load_cksum_err, load_fmt_err} == flags_before, "R10",
              "outcome held", int'({load_done, load_cksum_err, load_fmt_err}),
              int'(flags_before));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd31337);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11: idle after reset
        check(!tape_ready && !wr_en && !any_flag(), "R11", "reset state",
              int'({tape_ready, wr_en, load_done, load_cksum_err, load_fmt_err}), 0);

        // R1 R3 R4: long leader, one record, eleven zeros
        tlen = 0;
        push_zeros(40);
        add_record(3, 5, 8'h77, 1'b0, 0);
        push_zeros(11);
        run_load("R1 R3 R4");

        // R8: gap of exactly ten zeros continues into the next record
        tlen = 0;
        add_record(2, 10, 8'h01, 1'b0, 0);
        push_zeros(10);
        add_record(2, 20, 8'h02, 1'b0, 0);
        run_load("R8");

        // R8: eleven zeros stop the load, the record after is not written
        tlen = 0;
        add_record(2, 30, 8'h03, 1'b0, 0);
        push_zeros(11);
        add_record(3, 40, 8'h04, 1'b0, 0);
        run_load("R8");

        // R2: filler bytes of zero and all ones
        tlen = 0;
        add_record(2, 1, 8'h00, 1'b0, 0);
        push_zeros(2);
        add_record(2, 3, 8'hFF, 1'b0, 0);
        push_zeros(11);
        run_load("R2");

        // R5: corrupted checksum stops the load after the words were written
        tlen = 0;
        add_record(4, 8, 8'h10, 1'b1, 0);
        add_record(2, 50, 8'h10, 1'b0, 0);
        run_load("R5");

        // R5: sum wraps modulo 2^16
        tlen = 0;
        add_record(6, 16'hFFF0 & 16'h0030, 8'h20, 1'b0, 1);
        push_zeros(11);
        run_load("R5");

        // R6: tape ends inside data
        tlen = 0;
        add_record(4, 12, 8'h30, 1'b0, 0);
        tlen = tlen - 5;
        run_load("R6");

        // R6: tape ends right after the count byte
        tlen = 0;
        push_zeros(3);
        push(5);
        run_load("R6");

        // R9: empty tape and a leader of zeros only
        tlen = 0;
        run_load("R9");
        tlen = 0;
        push_zeros(25);
        run_load("R9");

        // R7: record runs off the top of memory; far origin is dropped entirely
        tlen = 0;
        add_record(4, 62, 8'h40, 1'b0, 0);
        add_record(3, 16'hFFFE, 8'h41, 1'b0, 0);
        add_record(1, 0, 8'h42, 1'b0, 0);
        push_zeros(11);
        run_load("R7");

        // random tapes
        for (int t = 0; t < 30; t++) begin
            int nrec;
            int mode;
            tlen = 0;
            push_zeros($urandom % 15);
            nrec = 1 + $urandom % 3;
            for (int r = 0; r < nrec; r++) begin
                add_record(1 + $urandom % 5, $urandom % 80, $urandom % 256,
                           ($urandom % 6) == 0, $urandom % 2);
                if (r < nrec - 1) push_zeros($urandom % 11);
            end
            mode = $urandom % 4;
            case (mode)
                1: begin
                    push_zeros(11);
                    add_record(2, $urandom % 64, 8'h55, 1'b0, 0);
                end
                2: tlen = tlen - (1 + $urandom % 3);
                3: push_zeros(5);
                default: ;
            endcase
            run_load("R4 R7");
        end

        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
        $finish;
    end

endmodule